// File: doc/BRIEF.md
# Single-line bus master timing engine

This block is the master side of a single open-drain data line shared by slave devices. A host hands it one command at a time: a bus reset with presence detection, an eight-bit write, an eight-bit read, or a strong-pullup hold of a chosen number of microseconds. The block turns each command into microsecond-exact line activity. When the command is complete it returns a one-cycle done pulse, together with the presence flag or the received byte.

The line is modelled as two signals. `line_low` enables the pull-down driver and `line_in` is the sensed level, which is resynchronised through two flops before use. A separate `spu_en` output switches a low-impedance pullup on while a slave runs a conversion or a non-volatile copy. That pullup can follow a write command directly, so the host need not react within the short gap that is allowed. Time comes from a one-microsecond tick divided from `CLK_HZ`. Every phase length is a parameter in microseconds.

Top module: `sline_master`

## Requirements
- R1: A reset command (op 00) holds `line_low` high for exactly RST_LOW_US microseconds (480 to 960), then releases the line for RST_WAIT_US microseconds before done.
- R2: The presence flag takes the inverse of the synchronised line, sampled PRES_US microseconds after the reset release, and is valid at done. It reads 1 when a slave answers and 0 when none does.
- R3: In a write command (op 01) each slot lasts SLOT_US microseconds. A 1 bit pulls low for LOW_US microseconds. A 0 bit pulls low for the whole slot.
- R4: A written byte goes out least significant bit first, so the eight slots in order carry cmd_data bit 0 through bit 7.
- R5: Consecutive slots are separated by at least RECOV_US microseconds of released line.
- R6: In a read command (op 10) each slot pulls low for LOW_US microseconds and then releases. The line is sampled SAMPLE_US microseconds after the slot start. The bits fill rx_data least significant bit first, and rx_data is valid at done.
- R7: A write with a nonzero cmd_hold_us raises `spu_en` within 10 microseconds after the end of the last slot and holds it for exactly cmd_hold_us microseconds. `line_low` stays low throughout. A write with zero hold never raises `spu_en`.
- R8: A pullup command (op 11) holds `spu_en` for exactly cmd_hold_us microseconds. With zero hold it gives done at once and leaves `spu_en` low.
- R9: A command is accepted only when idle. `busy` is high from acceptance until the single-cycle done pulse. A command presented while busy is ignored.
- R10: After reset, the line is released, `spu_en`, `busy`, `done` and `presence` are low, and rx_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 00 reset, 01 write, 10 read, 11 pullup |
| cmd_data | input | 8 | Byte to write |
| cmd_hold_us | input | HOLD_W | Strong-pullup time in microseconds |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | A slave answered the last reset |
| rx_data | output | 8 | Byte from the last read |
| line_low | output | 1 | Pull-down enable for the data line |
| line_in | input | 1 | Sensed data line level |
| spu_en | output | 1 | Strong pullup enable |

## Verification
The bench sets CLK_HZ to 4 MHz, so one microsecond is four cycles of its clock, and keeps every timing parameter at its default. Every pulse, slot and pullup width can then be measured in whole cycles against the real microsecond values. A full reset and several bytes each way stay cheap to run. A slave model answers resets and read slots on the line, which exercises presence both ways and the sample point inside the early valid window.

// File: rtl/sline_pkg.sv
package sline_pkg;

  typedef enum logic [1:0] {
    OP_RESET  = 2'b00,
    OP_WRITE  = 2'b01,
    OP_READ   = 2'b10,
    OP_PULLUP = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RLOW,
    ST_RWAIT,
    ST_SLOT,
    ST_RECOV,
    ST_SPU
  } st_e;

endpackage

// File: rtl/sline_tick.sv
module sline_tick #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      logic clr_seen;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_seen <= 1'b0;
        else        clr_seen <= clr;
      end
      assign tick = 1'b1 | clr_seen;
    end else begin : g_div
      localparam int DW = $clog2(DIV);
      logic [DW-1:0] div_q, div_d;

      assign tick = (div_q == DW'(DIV - 1));

      always_comb begin
        if (clr || tick) div_d = '0;
        else             div_d = div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      // R3: ticks are isolated, so slot lengths are whole periods
      p_tick_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/sline_sync.sv
module sline_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/sline_master.sv
module sline_master
  import sline_pkg::*;
#(
  parameter int CLK_HZ      = 250_000_000,
  parameter int RST_LOW_US  = 500,
  parameter int RST_WAIT_US = 480,
  parameter int PRES_US     = 70,
  parameter int SLOT_US     = 70,
  parameter int LOW_US      = 6,
  parameter int SAMPLE_US   = 13,
  parameter int RECOV_US    = 2,
  parameter int HOLD_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_data,
  input  logic [HOLD_W-1:0] cmd_hold_us,
  output logic              busy,
  output logic              done,
  output logic              presence,
  output logic [7:0]        rx_data,
  output logic              line_low,
  input  logic              line_in,
  output logic              spu_en
);

  localparam int TICK_DIV = CLK_HZ / 1_000_000;
  localparam int T_MAX    = (RST_LOW_US > RST_WAIT_US) ? RST_LOW_US : RST_WAIT_US;
  localparam int T_W      = $clog2(T_MAX + 1);
  localparam int CNT_W    = (HOLD_W > T_W) ? HOLD_W : T_W;

  localparam logic [CNT_W-1:0] RLOW_LAST  = CNT_W'(RST_LOW_US - 1);
  localparam logic [CNT_W-1:0] RWAIT_LAST = CNT_W'(RST_WAIT_US - 1);
  localparam logic [CNT_W-1:0] PRES_LAST  = CNT_W'(PRES_US - 1);
  localparam logic [CNT_W-1:0] SLOT_LAST  = CNT_W'(SLOT_US - 1);
  localparam logic [CNT_W-1:0] SAMP_LAST  = CNT_W'(SAMPLE_US - 1);
  localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(RECOV_US - 1);
  localparam logic [CNT_W-1:0] LOW_LIM    = CNT_W'(LOW_US);

  localparam int MAX_LOW_CLK = 960 * TICK_DIV;
  localparam int LR_W        = $clog2(MAX_LOW_CLK + 2);

  logic tick, tick_clr, line_s;

  sline_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
  );

  sline_sync u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  st_e               st_q, st_d;
  op_e               op_q, op_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [2:0]        bit_q, bit_d;
  logic [7:0]        sh_q, sh_d, rx_q, rx_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              pres_q, pres_d, done_q, done_d;

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    cnt_d    = cnt_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    hold_d   = hold_q;
    pres_d   = pres_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    tick_clr = 1'b0;
    cnt_inc  = cnt_q + 1'b1;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          tick_clr = 1'b1;
          cnt_d    = '0;
          bit_d    = '0;
          sh_d     = cmd_data;
          op_d     = op_e'(cmd_op);
          hold_d   = cmd_hold_us;
          case (op_e'(cmd_op))
            OP_RESET: begin
              st_d   = ST_RLOW;
              pres_d = 1'b0;
            end
            OP_WRITE, OP_READ: st_d = ST_SLOT;
            default: begin
              if (cmd_hold_us != '0) st_d = ST_SPU;
              else                   done_d = 1'b1;
            end
          endcase
        end
      end
      ST_RLOW: begin
        if (tick) begin
          if (cnt_q == RLOW_LAST) begin
            st_d  = ST_RWAIT;
            cnt_d = '0;
          end else cnt_d = cnt_inc;
        end
      end
      ST_RWAIT: begin
        if (tick) begin
          if (cnt_q == PRES_LAST) pres_d = ~line_s;
          if (cnt_q == RWAIT_LAST) begin
            st_d   = ST_IDLE;
            cnt_d  = '0;
            done_d = 1'b1;
          end else cnt_d = cnt_inc;
        end
      end
      ST_SLOT: begin
        if (tick) begin
          if (op_q == OP_READ && cnt_q == SAMP_LAST) sh_d = {line_s, sh_q[7:1]};
          if (cnt_q == SLOT_LAST) begin
            st_d  = ST_RECOV;
            cnt_d = '0;
            if (op_q == OP_WRITE) sh_d = {1'b0, sh_q[7:1]};
          end else cnt_d = cnt_inc;
        end
      end
      ST_RECOV: begin
        if (tick) begin
          if (cnt_q == REC_LAST) begin
            cnt_d = '0;
            if (bit_q == 3'd7) begin
              if (op_q == OP_READ) rx_d = sh_q;
              if (op_q == OP_WRITE && hold_q != '0) st_d = ST_SPU;
              else begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
              end
            end else begin
              bit_d = bit_q + 1'b1;
              st_d  = ST_SLOT;
            end
          end else cnt_d = cnt_inc;
        end
      end
      ST_SPU: begin
        if (tick) begin
          if (cnt_inc == CNT_W'(hold_q)) begin
            st_d   = ST_IDLE;
            cnt_d  = '0;
            done_d = 1'b1;
          end else cnt_d = cnt_inc;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_RESET;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      hold_q <= '0;
      pres_q <= 1'b0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      hold_q <= hold_d;
      pres_q <= pres_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign line_low = (st_q == ST_RLOW) ||
                    ((st_q == ST_SLOT) &&
                     ((cnt_q < LOW_LIM) || (op_q == OP_WRITE && !sh_q[0])));
  assign spu_en   = (st_q == ST_SPU);
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign presence = pres_q;
  assign rx_data  = rx_q;

  // Run length of the pull-down, kept only for the bound check below
  logic [LR_W-1:0] lowrun_q, lowrun_d;
  always_comb begin
    if (!line_low)                              lowrun_d = '0;
    else if (lowrun_q == LR_W'(MAX_LOW_CLK + 1)) lowrun_d = lowrun_q;
    else                                        lowrun_d = lowrun_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowrun_q <= '0;
    else        lowrun_q <= lowrun_d;
  end

  p_low_within_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lowrun_q <= LR_W'(MAX_LOW_CLK));

  p_presence_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> $stable(presence));

  p_spu_quiet_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spu_en |-> !line_low);

  p_busy_from_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  p_busy_ends_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sline_master_test.sv
`timescale 1ns/1ps
module sline_master_test;

  localparam int Q      = 4;   // clocks per microsecond
  localparam int HOLD_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic [HOLD_W-1:0] cmd_hold_us = '0;
  logic busy, done, presence, line_low, spu_en, line_in;
  logic [7:0] rx_data;

  always #2 clk = ~clk;

  sline_master #(.CLK_HZ(4_000_000), .HOLD_W(HOLD_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_hold_us(cmd_hold_us), .busy(busy), .done(done),
    .presence(presence), .rx_data(rx_data), .line_low(line_low),
    .line_in(line_in), .spu_en(spu_en)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model and scoreboard
  int mode = 0;          // 0 reset, 1 write, 2 read, 3 pullup
  int last_op = 0;
  bit slave_on = 1;
  logic [7:0] sl_byte = 8'h00;
  int sl_idx = 0;
  int slave_cnt = 0, pres_dly = 0, pres_len = 0;
  assign line_in = !(line_low || slave_cnt > 0 || pres_len > 0);

  byte unsigned exp_wr[$];
  byte unsigned exp_rd[$];
  bit exp_pres[$];
  int exp_spu[$];

  bit prev_low = 0, prev_spu = 0;
  int lowcnt = 0, highcnt = 1000, since_start = 0, spucnt = 0;
  int n_starts = 0, n_spu = 0, n_done = 0, wr_idx = 0;
  logic [7:0] wr_byte = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (slave_cnt > 0) slave_cnt--;
      if (pres_len > 0) pres_len--;
      if (pres_dly > 0) begin
        pres_dly--;
        if (pres_dly == 0) pres_len = 100 * Q;
      end
      if (line_low && !prev_low) begin
        n_starts++;
        chk(highcnt >= 2 * Q, "R5 recovery", highcnt, 2 * Q);
        lowcnt = 0;
        since_start = 0;
        if (mode == 2) begin
          if (!sl_byte[sl_idx]) slave_cnt = 30 * Q;
          sl_idx++;
        end
      end
      if (!line_low && prev_low) begin
        if (lowcnt >= 480 * Q) begin
          chk(lowcnt == 500 * Q, "R1 reset low", lowcnt, 500 * Q);
          if (slave_on) pres_dly = 20 * Q;
        end else if (mode == 1) begin
          if (lowcnt > 15 * Q) begin
            chk(lowcnt == 70 * Q, "R3 write0 low", lowcnt, 70 * Q);
            wr_byte[wr_idx] = 1'b0;
          end else begin
            chk(lowcnt == 6 * Q, "R3 write1 low", lowcnt, 6 * Q);
            wr_byte[wr_idx] = 1'b1;
          end
          wr_idx++;
          if (wr_idx == 8) begin
            wr_idx = 0;
            if (exp_wr.size() == 0) chk(0, "R4 unexpected byte", wr_byte, -1);
            else begin
              automatic byte unsigned e = exp_wr.pop_front();
              chk(wr_byte == e, "R4 byte on line", wr_byte, e);
            end
          end
        end else if (mode == 2) begin
          chk(lowcnt == 6 * Q, "R6 read low", lowcnt, 6 * Q);
        end
        highcnt = 0;
      end
      if (spu_en && !prev_spu) begin
        n_spu++;
        spucnt = 0;
        if (mode == 1)
          chk(since_start >= 72 * Q && since_start <= 80 * Q, "R7 pullup delay",
              since_start, 72 * Q);
      end
      if (!spu_en && prev_spu) begin
        if (exp_spu.size() == 0) chk(0, "R7 unexpected pullup", spucnt, -1);
        else begin
          automatic int e = exp_spu.pop_front();
          chk(spucnt == e, "R7 R8 pullup width", spucnt, e);
        end
      end
      if (spu_en && line_low) chk(0, "R7 line pulled during pullup", 1, 0);
      if (done) begin
        n_done++;
        if (last_op == 2) begin
          if (exp_rd.size() == 0) chk(0, "R6 unexpected read", rx_data, -1);
          else begin
            automatic byte unsigned e = exp_rd.pop_front();
            chk(rx_data == e, "R6 rx_data", rx_data, e);
          end
        end else if (last_op == 0) begin
          if (exp_pres.size() == 0) chk(0, "R2 unexpected reset", presence, -1);
          else begin
            automatic bit e = exp_pres.pop_front();
            chk(presence == e, "R2 presence", presence, e);
          end
        end
      end
      if (line_low) lowcnt++; else highcnt++;
      since_start++;
      if (spu_en) spucnt++;
      prev_low = line_low;
      prev_spu = spu_en;
    end
  end

  task automatic run(input int op, input logic [7:0] d, input int hold);
    while (busy) @(negedge clk);
    mode = op;
    last_op = op;
    cmd_op = op[1:0];
    cmd_data = d;
    cmd_hold_us = HOLD_W'(hold);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 3 && hold == 0) chk(busy == 0 && done == 1, "R8 zero hold", busy, 0);
    else chk(busy == 1, "R9 busy after accept", busy, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit present);
    slave_on = present;
    exp_pres.push_back(present);
    run(0, 8'h00, 0);
  endtask

  task automatic do_write(input logic [7:0] d, input int hold);
    exp_wr.push_back(d);
    if (hold != 0) exp_spu.push_back(hold * Q);
    run(1, d, hold);
  endtask

  task automatic do_read(input logic [7:0] d);
    sl_byte = d;
    sl_idx = 0;
    exp_rd.push_back(d);
    run(2, 8'h00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(line_low == 0 && spu_en == 0 && busy == 0 && done == 0 && presence == 0
        && rx_data == 0, "R10 reset state", {line_low, spu_en, busy, done, presence}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    do_reset(1);                 // R1 R2 slave answers
    do_reset(0);                 // R2 empty bus
    do_write(8'hA5, 0);          // R3 R4 R5
    do_write(8'h00, 0);
    do_write(8'hFF, 0);
    do_write(8'h44, 50);         // R7 pullup after write
    begin
      automatic int s = n_spu;
      do_write(8'h3C, 0);
      chk(n_spu == s, "R7 no pullup at zero hold", n_spu, s);
    end
    do_read(8'h5A);              // R6
    do_read(8'h00);
    do_read(8'hFF);
    do_read(8'hC3);
    exp_spu.push_back(30 * Q);   // R8 standalone pullup
    run(3, 8'h00, 30);
    begin
      automatic int s = n_spu;
      run(3, 8'h00, 0);
      chk(n_spu == s, "R8 no pullup at zero hold", n_spu, s);
    end

    // R9 a command while busy is ignored
    begin
      automatic int st, dn;
      exp_wr.push_back(8'h96);
      mode = 1; last_op = 1;
      cmd_op = 2'b01; cmd_data = 8'h96; cmd_hold_us = '0;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (200) @(negedge clk);
      cmd_op = 2'b10; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      dn = n_done;
      while (!done) @(negedge clk);
      @(negedge clk);
      st = n_starts;
      dn = n_done;
      repeat (200 * Q) @(negedge clk);
      chk(busy == 0, "R9 ignored command left idle", busy, 0);
      chk(n_starts == st, "R9 ignored command made no slot", n_starts, st);
      chk(n_done == dn, "R9 ignored command made no done", n_done, dn);
    end

    chk(exp_wr.size() == 0, "R4 all bytes seen", exp_wr.size(), 0);
    chk(exp_rd.size() == 0, "R6 all reads done", exp_rd.size(), 0);
    chk(exp_spu.size() == 0, "R7 all pullups seen", exp_spu.size(), 0);
    chk(exp_pres.size() == 0, "R2 all resets done", exp_pres.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule